// File: doc/BRIEF.md
# DRAM Command Decoder with Bank-State Legality Check

This block sits at the command edge of a double-data-rate DRAM model or controller monitor. On every rising clock edge it samples chip select, the three command strobes, the clock enable, the bank address and the address bus. It folds the current and previous clock-enable values, the strobe pattern, address bit 10 and bank address bit 0 into one decode, and registers the resulting command code, bank index, address field and auto-precharge flag.

The block keeps a small model of which banks hold an open row. It also keeps a self-refresh flag and a short timer that runs after a mode-register load. From this state it raises an illegal flag for one cycle when a command breaks a precondition. The decoded command is still reported with that flag. Illegal commands change no state. Electrical behaviour and the data path are out of scope.

Top module: `cmdtt_decoder`

## Requirements
- R1: All outputs are registered and reflect the inputs sampled at the previous rising edge. An asynchronous active-low reset clears the outputs to zero, marks all banks idle and sets the remembered clock enable to high.
- R2: With chip select high and clock enable high in both cycles, the command is deselect (code 0), and bank_o, addr_o and auto_pre_o are 0 whatever the other inputs are.
- R3: With chip select low and clock enable high in both cycles, the strobes {ras_n,cas_n,we_n} decode as follows: 111 nop (1), 011 activate (7), 101 read (8), 100 write (9), 110 burst stop (10).
- R4: Strobes 000 give a mode register load. ba[0]=0 selects the normal register (code 2) and ba[0]=1 the extended register (code 3). addr_o carries the full address as the opcode and bank_o carries ba.
- R5: Strobes 001 with clock enable high in both cycles give auto refresh (4). With clock enable falling they give self-refresh entry (5).
- R6: For read and write, addr[10] drives auto_pre_o. addr_o is the address with bit 10 cleared, and bank_o is ba, where ba[0] is the low bit (banks A to D are 0 to 3).
- R7: Strobes 010 give precharge of bank ba (11) when addr[10]=0. When addr[10]=1 they give precharge-all (12), with bank_o=0 and addr_o=0, and every bank is closed.
- R8: A falling clock enable with any non-refresh command gives power-down entry (13). Clock enable low in both cycles gives hold (15). A rising clock enable gives self-refresh exit (6) if self refresh was entered, else power-down exit (14).
- R9: Mode register load, auto refresh and self-refresh entry are illegal while any bank is open.
- R10: In the MRD_CYC-1 cycles after a legal mode register load, any command other than deselect, nop or hold is illegal.
- R11: Activate to an open bank is illegal, and read or write to an idle bank is illegal.
- R12: An illegal command is reported with illegal_o high for that cycle only. It opens or closes no bank, starts no timer and sets no self-refresh flag.
- R13: A legal read or write with auto-precharge closes its bank.
- R14: Power-down entry while the strobes carry a command other than nop or deselect is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock enable |
| ba | input | BANK_W | Bank address |
| addr | input | ADDR_W | Address bus |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | BANK_W | Bank index of the command |
| addr_o | output | ADDR_W | Row, column or opcode |
| auto_pre_o | output | 1 | Auto-precharge request on read or write |
| illegal_o | output | 1 | Precondition violated this cycle |

## Verification
Two checks can meet in one cycle. A clock-enable transition takes priority over the strobe pattern, while the legality check still looks at that pattern. The bench drives an activate strobe together with a falling clock enable. It expects power-down entry with the illegal flag set, and no bank opened, which a later read reveals. In the same way, the mode-register timer and the bank-state check can both act on one activate. The bench issues an activate in the cycle right after an extended-register load. It expects the flag, and a legal activate to the same bank two cycles later.

// File: rtl/cmdtt_pkg.sv
package cmdtt_pkg;
    typedef enum logic [3:0] {
        CMD_DESEL    = 4'd0,
        CMD_NOP      = 4'd1,
        CMD_MRS      = 4'd2,
        CMD_EMRS     = 4'd3,
        CMD_AREF     = 4'd4,
        CMD_SREF_IN  = 4'd5,
        CMD_SREF_OUT = 4'd6,
        CMD_ACT      = 4'd7,
        CMD_RD       = 4'd8,
        CMD_WR       = 4'd9,
        CMD_BST      = 4'd10,
        CMD_PRE      = 4'd11,
        CMD_PREA     = 4'd12,
        CMD_PDN_IN   = 4'd13,
        CMD_PDN_OUT  = 4'd14,
        CMD_HOLD     = 4'd15
    } cmd_e;

    typedef enum logic [3:0] {
        RAW_DESEL = 4'd0,
        RAW_MODE  = 4'd1,
        RAW_REF   = 4'd2,
        RAW_PRE   = 4'd3,
        RAW_ACT   = 4'd4,
        RAW_WR    = 4'd5,
        RAW_RD    = 4'd6,
        RAW_BST   = 4'd7,
        RAW_NOP   = 4'd8
    } raw_e;
endpackage

// File: rtl/cmdtt_strobe_dec.sv
module cmdtt_strobe_dec
    import cmdtt_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output raw_e raw
);
    always_comb begin
        if (cs_n) begin
            raw = RAW_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b000:  raw = RAW_MODE;
                3'b001:  raw = RAW_REF;
                3'b010:  raw = RAW_PRE;
                3'b011:  raw = RAW_ACT;
                3'b100:  raw = RAW_WR;
                3'b101:  raw = RAW_RD;
                3'b110:  raw = RAW_BST;
                default: raw = RAW_NOP;
            endcase
        end
    end
endmodule

// File: rtl/cmdtt_bank_track.sv
module cmdtt_bank_track #(
    parameter int BANK_W = 2,
    localparam int NBANK = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_en,
    input  logic              close_en,
    input  logic              close_all,
    input  logic [BANK_W-1:0] bank,
    output logic [NBANK-1:0]  open_o
);
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic row_d, row_q;
        always_comb begin
            row_d = row_q;
            if (close_all || (close_en && bank == BANK_W'(b))) row_d = 1'b0;
            else if (open_en && bank == BANK_W'(b))           row_d = 1'b1;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) row_q <= 1'b0;
            else        row_q <= row_d;
        end
        assign open_o[b] = row_q;
    end
endmodule

// File: rtl/cmdtt_mrd_timer.sv
module cmdtt_mrd_timer #(
    parameter int MRD_CYC = 2,
    localparam int CW = $clog2(MRD_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)              cnt_d = CW'(MRD_CYC - 1);
        else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/cmdtt_decoder.sv
module cmdtt_decoder
    import cmdtt_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int BANK_W  = 2,
    parameter int AP_BIT  = 10,
    parameter int MRD_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              cke,
    input  logic [BANK_W-1:0] ba,
    input  logic [ADDR_W-1:0] addr,
    output logic [3:0]        cmd_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              auto_pre_o,
    output logic              illegal_o
);
    localparam int NBANK = 1 << BANK_W;

    typedef struct packed {
        cmd_e              cmd;
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] addr;
        logic              ap;
        logic              ill;
        logic              sref;
        logic              cke;
    } st_t;

    st_t st_d, st_q;

    raw_e             raw;
    logic [NBANK-1:0] open_mask;
    logic             mrd_busy;
    logic             open_en, close_en, close_all, mrd_start;
    cmd_e             cmd;
    logic             ill;

    cmdtt_strobe_dec u_strobe (
        .cs_n (cs_n),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .we_n (we_n),
        .raw  (raw)
    );

    cmdtt_bank_track #(.BANK_W(BANK_W)) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_en  (open_en),
        .close_en (close_en),
        .close_all(close_all),
        .bank     (ba),
        .open_o   (open_mask)
    );

    cmdtt_mrd_timer #(.MRD_CYC(MRD_CYC)) u_mrd (
        .clk  (clk),
        .rst_n(rst_n),
        .start(mrd_start),
        .busy (mrd_busy)
    );

    // Command selection: clock-enable history first, then the strobes.
    always_comb begin
        if (!st_q.cke) begin
            if (cke) cmd = st_q.sref ? CMD_SREF_OUT : CMD_PDN_OUT;
            else     cmd = CMD_HOLD;
        end else if (!cke) begin
            cmd = (raw == RAW_REF) ? CMD_SREF_IN : CMD_PDN_IN;
        end else begin
            unique case (raw)
                RAW_DESEL: cmd = CMD_DESEL;
                RAW_MODE:  cmd = ba[0] ? CMD_EMRS : CMD_MRS;
                RAW_REF:   cmd = CMD_AREF;
                RAW_PRE:   cmd = addr[AP_BIT] ? CMD_PREA : CMD_PRE;
                RAW_ACT:   cmd = CMD_ACT;
                RAW_WR:    cmd = CMD_WR;
                RAW_RD:    cmd = CMD_RD;
                RAW_BST:   cmd = CMD_BST;
                default:   cmd = CMD_NOP;
            endcase
        end
    end

    // Legality against bank state and the mode-register gap.
    always_comb begin
        ill = 1'b0;
        unique case (cmd)
            CMD_MRS, CMD_EMRS, CMD_AREF, CMD_SREF_IN: ill = |open_mask;
            CMD_ACT:    ill = open_mask[ba];
            CMD_RD, CMD_WR: ill = !open_mask[ba];
            CMD_PDN_IN: ill = !(raw == RAW_DESEL || raw == RAW_NOP);
            default:    ill = 1'b0;
        endcase
        if (mrd_busy && !(cmd == CMD_DESEL || cmd == CMD_NOP || cmd == CMD_HOLD))
            ill = 1'b1;
    end

    always_comb begin
        open_en   = !ill && (cmd == CMD_ACT);
        close_en  = !ill && ((cmd == CMD_PRE) ||
                     ((cmd == CMD_RD || cmd == CMD_WR) && addr[AP_BIT]));
        close_all = !ill && (cmd == CMD_PREA);
        mrd_start = !ill && (cmd == CMD_MRS || cmd == CMD_EMRS);
    end

    always_comb begin
        st_d      = st_q;
        st_d.cmd  = cmd;
        st_d.ill  = ill;
        st_d.cke  = cke;
        st_d.ap   = 1'b0;
        st_d.bank = '0;
        st_d.addr = '0;
        unique case (cmd)
            CMD_MRS, CMD_EMRS, CMD_ACT: begin
                st_d.bank = ba;
                st_d.addr = addr;
            end
            CMD_RD, CMD_WR: begin
                st_d.bank = ba;
                st_d.addr = addr;
                st_d.addr[AP_BIT] = 1'b0;
                st_d.ap   = addr[AP_BIT];
            end
            CMD_PRE: st_d.bank = ba;
            default: ;
        endcase
        if (cmd == CMD_SREF_IN && !ill)                       st_d.sref = 1'b1;
        else if (cmd == CMD_SREF_OUT || cmd == CMD_PDN_OUT)   st_d.sref = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cke  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o      = st_q.cmd;
    assign bank_o     = st_q.bank;
    assign addr_o     = st_q.addr;
    assign auto_pre_o = st_q.ap;
    assign illegal_o  = st_q.ill;
endmodule

// File: rtl/cmdtt_decoder_chk.sv
module cmdtt_decoder_chk
    import cmdtt_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BANK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              cke,
    input logic [3:0]        cmd_o,
    input logic [BANK_W-1:0] bank_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              auto_pre_o,
    input logic              illegal_o
);
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= 2'd0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end

    // R6: auto-precharge only accompanies read or write
    p_ap_only_rdwr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        auto_pre_o |-> (cmd_o == CMD_RD || cmd_o == CMD_WR));

    // R7: precharge-all carries no bank and no address
    p_prea_no_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_PREA) |-> (bank_o == '0 && addr_o == '0));

    // R2: deselected with clock enable steady high decodes as deselect
    p_cs_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && $past(cs_n) && $past(cke) && $past(cke, 2))
        |-> (cmd_o == CMD_DESEL));

    // R10: command right after an accepted mode load is flagged unless idle
    p_mrd_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_o == CMD_MRS || cmd_o == CMD_EMRS) && !illegal_o)
        |=> (cmd_o == CMD_DESEL || cmd_o == CMD_NOP || cmd_o == CMD_HOLD || illegal_o));

    // R11: back-to-back activate to one bank is flagged
    p_act_twice_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_ACT && !illegal_o)
        |=> ((cmd_o == CMD_ACT && bank_o == $past(bank_o)) -> illegal_o));
endmodule

bind cmdtt_decoder cmdtt_decoder_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .cke       (cke),
    .cmd_o     (cmd_o),
    .bank_o    (bank_o),
    .addr_o    (addr_o),
    .auto_pre_o(auto_pre_o),
    .illegal_o (illegal_o)
);

// File: tb/sim_cmdtt_decoder.sv
module sim_cmdtt_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
    logic [1:0]  ba = 2'd0;
    logic [12:0] addr = 13'd0;
    logic [3:0]  cmd_o;
    logic [1:0]  bank_o;
    logic [12:0] addr_o;
    logic        auto_pre_o, illegal_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cmdtt_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .cmd_o(cmd_o),
        .bank_o(bank_o), .addr_o(addr_o), .auto_pre_o(auto_pre_o),
        .illegal_o(illegal_o)
    );

    typedef struct packed {
        logic [3:0]  strb;   // {cs_n, ras_n, cas_n, we_n}
        logic        cke;
        logic [1:0]  ba;
        logic [12:0] a;
        logic [3:0]  ecmd;
        logic [1:0]  ebank;
        logic [12:0] eaddr;
        logic        eap;
        logic        eill;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VECS [NV] = '{
        '{4'b1000, 1'b1, 2'd3, 13'h1FFF, 4'd0,  2'd0, 13'h0000, 1'b0, 1'b0, 4'd2},  // R2
        '{4'b0111, 1'b1, 2'd0, 13'h0000, 4'd1,  2'd0, 13'h0000, 1'b0, 1'b0, 4'd3},  // R3
        '{4'b0000, 1'b1, 2'd0, 13'h0032, 4'd2,  2'd0, 13'h0032, 1'b0, 1'b0, 4'd4},  // R4
        '{4'b0111, 1'b1, 2'd0, 13'h0000, 4'd1,  2'd0, 13'h0000, 1'b0, 1'b0, 4'd10}, // R10
        '{4'b0000, 1'b1, 2'd1, 13'h0002, 4'd3,  2'd1, 13'h0002, 1'b0, 1'b0, 4'd4},  // R4
        '{4'b0011, 1'b1, 2'd2, 13'h1ABC, 4'd7,  2'd2, 13'h1ABC, 1'b0, 1'b1, 4'd10}, // R10
        '{4'b0111, 1'b1, 2'd0, 13'h0000, 4'd1,  2'd0, 13'h0000, 1'b0, 1'b0, 4'd12}, // R12
        '{4'b0011, 1'b1, 2'd2, 13'h0123, 4'd7,  2'd2, 13'h0123, 1'b0, 1'b0, 4'd3},  // R3
        '{4'b0011, 1'b1, 2'd2, 13'h0001, 4'd7,  2'd2, 13'h0001, 1'b0, 1'b1, 4'd11}, // R11
        '{4'b0101, 1'b1, 2'd1, 13'h0010, 4'd8,  2'd1, 13'h0010, 1'b0, 1'b1, 4'd11}, // R11
        '{4'b0101, 1'b1, 2'd2, 13'h0410, 4'd8,  2'd2, 13'h0010, 1'b1, 1'b0, 4'd6},  // R6
        '{4'b0100, 1'b1, 2'd2, 13'h0005, 4'd9,  2'd2, 13'h0005, 1'b0, 1'b1, 4'd13}, // R13
        '{4'b0001, 1'b1, 2'd0, 13'h0000, 4'd4,  2'd0, 13'h0000, 1'b0, 1'b0, 4'd5},  // R5
        '{4'b0011, 1'b1, 2'd1, 13'h0200, 4'd7,  2'd1, 13'h0200, 1'b0, 1'b0, 4'd3},  // R3
        '{4'b0001, 1'b1, 2'd0, 13'h0000, 4'd4,  2'd0, 13'h0000, 1'b0, 1'b1, 4'd9},  // R9
        '{4'b0000, 1'b1, 2'd0, 13'h0033, 4'd2,  2'd0, 13'h0033, 1'b0, 1'b1, 4'd9},  // R9
        '{4'b0100, 1'b1, 2'd1, 13'h0008, 4'd9,  2'd1, 13'h0008, 1'b0, 1'b0, 4'd12}, // R12
        '{4'b0110, 1'b1, 2'd0, 13'h0000, 4'd10, 2'd0, 13'h0000, 1'b0, 1'b0, 4'd3},  // R3
        '{4'b0010, 1'b1, 2'd1, 13'h0000, 4'd11, 2'd1, 13'h0000, 1'b0, 1'b0, 4'd7},  // R7
        '{4'b0011, 1'b1, 2'd3, 13'h0FFF, 4'd7,  2'd3, 13'h0FFF, 1'b0, 1'b0, 4'd3},  // R3
        '{4'b0011, 1'b1, 2'd0, 13'h0001, 4'd7,  2'd0, 13'h0001, 1'b0, 1'b0, 4'd3},  // R3
        '{4'b0010, 1'b1, 2'd2, 13'h0400, 4'd12, 2'd0, 13'h0000, 1'b0, 1'b0, 4'd7},  // R7
        '{4'b0011, 1'b1, 2'd3, 13'h0002, 4'd7,  2'd3, 13'h0002, 1'b0, 1'b0, 4'd7},  // R7
        '{4'b0010, 1'b1, 2'd3, 13'h0000, 4'd11, 2'd3, 13'h0000, 1'b0, 1'b0, 4'd7},  // R7
        '{4'b0001, 1'b0, 2'd0, 13'h0000, 4'd5,  2'd0, 13'h0000, 1'b0, 1'b0, 4'd5},  // R5
        '{4'b1111, 1'b0, 2'd0, 13'h0000, 4'd15, 2'd0, 13'h0000, 1'b0, 1'b0, 4'd8},  // R8
        '{4'b1111, 1'b1, 2'd0, 13'h0000, 4'd6,  2'd0, 13'h0000, 1'b0, 1'b0, 4'd8},  // R8
        '{4'b0111, 1'b1, 2'd0, 13'h0000, 4'd1,  2'd0, 13'h0000, 1'b0, 1'b0, 4'd3},  // R3
        '{4'b1111, 1'b0, 2'd0, 13'h0000, 4'd13, 2'd0, 13'h0000, 1'b0, 1'b0, 4'd8},  // R8
        '{4'b1111, 1'b0, 2'd0, 13'h0000, 4'd15, 2'd0, 13'h0000, 1'b0, 1'b0, 4'd8},  // R8
        '{4'b0111, 1'b1, 2'd0, 13'h0000, 4'd14, 2'd0, 13'h0000, 1'b0, 1'b0, 4'd8},  // R8
        '{4'b0011, 1'b0, 2'd0, 13'h0000, 4'd13, 2'd0, 13'h0000, 1'b0, 1'b1, 4'd14}, // R14
        '{4'b0111, 1'b1, 2'd0, 13'h0000, 4'd14, 2'd0, 13'h0000, 1'b0, 1'b0, 4'd8},  // R8
        '{4'b0101, 1'b1, 2'd0, 13'h0000, 4'd8,  2'd0, 13'h0000, 1'b0, 1'b1, 4'd12}  // R12
    };

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] s, input logic ck,
                         input logic [1:0] b, input logic [12:0] a);
        {cs_n, ras_n, cas_n, we_n} = s;
        cke  = ck;
        ba   = b;
        addr = a;
    endtask

    task automatic check_all(input int req, input logic [3:0] c, input logic [1:0] b,
                             input logic [12:0] a, input logic ap, input logic il);
        check(req, "cmd",     32'(cmd_o),      32'(c));
        check(req, "bank",    32'(bank_o),     32'(b));
        check(req, "addr",    32'(addr_o),     32'(a));
        check(req, "autopre", 32'(auto_pre_o), 32'(ap));
        check(req, "illegal", 32'(illegal_o),  32'(il));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check_all(1, 4'd0, 2'd0, 13'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].strb, VECS[i].cke, VECS[i].ba, VECS[i].a);
            @(posedge clk);
            @(negedge clk);
            check_all(int'(VECS[i].req), VECS[i].ecmd, VECS[i].ebank,
                      VECS[i].eaddr, VECS[i].eap, VECS[i].eill);
        end

        // R1: outputs hold last value until an edge, then follow
        drive(4'b0011, 1'b1, 2'd0, 13'h0044);
        #2;
        check(1, "registered cmd", 32'(cmd_o), 32'd8);
        @(posedge clk);
        @(negedge clk);
        check_all(1, 4'd7, 2'd0, 13'h0044, 1'b0, 1'b0);

        // R1: asynchronous reset mid-run clears state; bank 0 idle again
        rst_n = 1'b0;
        #2;
        check_all(1, 4'd0, 2'd0, 13'h0, 1'b0, 1'b0);
        drive(4'b0111, 1'b1, 2'd0, 13'h0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(4'b0101, 1'b1, 2'd0, 13'h0400);
        @(posedge clk);
        @(negedge clk);
        check(11, "read idle after reset", 32'(illegal_o), 32'd1);
        check(11, "read ap field", 32'(auto_pre_o), 32'd1);

        // R12: illegal pulse lasts one cycle
        drive(4'b0111, 1'b1, 2'd0, 13'h0);
        @(posedge clk);
        @(negedge clk);
        check(12, "pulse cleared", 32'(illegal_o), 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R1 watchdog: got %0h expected %0h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule